// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital half of a dual-slope integrating converter. It walks a fixed cycle of four phases (zeroing, input integration, reference run-down and integrator discharge) and drives one enable per phase to the analog switches. It watches one synchronous comparator bit, sampling it once per clock. The number of run-down clocks becomes the reading, so the reading is proportional to the input voltage over the reference voltage, scaled by the integration length. The reading comes with a sign, an over-range flag and an under-range flag.

Phase lengths depend on the previous result. Clocks left unused by an early run-down are added to the next zeroing phase, so with `run_i` high every measurement takes exactly `PERIOD` clocks. An over-range lengthens the discharge phase and shortens the zeroing phase that follows it. Pulling `run_i` low lets the current measurement finish. The block then parks in the zeroing phase and keeps the last reading.

Each reading leaves on a valid/ready port. The analog timing cannot stall, so there is no back-pressure into the sequencer. A reading that has not been taken stays stable until the next reading replaces it. `res_valid_o` then stays high. A ready in the same cycle as a new reading does not clear it.

Top module: `dslope_seq`

## Requirements
- R1: `phase_o` is one-hot, with bit 0 for zeroing, bit 1 for integrate, bit 2 for run-down and bit 3 for discharge. The phases follow that order cyclically, and the block leaves reset in zeroing.
- R2: Integrate lasts exactly `INT_CYCLES` clocks. The comparator value sampled in its last clock is the captured polarity. `res_neg_o` is 1 when that value was 0.
- R3: Run-down ends at the first clock whose sampled comparator differs from the captured polarity. `res_count_o` is the number of run-down clocks before that clock. Run-down never exceeds `DE_MAX` clocks.
- R4: If no differing sample arrives within `DE_MAX` clocks, `res_ovr_o` is set and `res_count_o` equals `DE_MAX`.
- R5: Discharge lasts `ZI_NORM` clocks, or `ZI_OVR` clocks after an over-range reading.
- R6: Zeroing lasts `PERIOD-INT_CYCLES-DE_MAX-ZI_NORM` clocks plus the run-down clocks left unused. After an over-range it lasts `PERIOD-INT_CYCLES-DE_MAX-ZI_OVR` clocks. With `run_i` high, each measurement spans `PERIOD` clocks.
- R7: If `run_i` is low when zeroing has run its length, the block stays in zeroing and keeps the reading. Integrate starts one clock after `run_i` is seen high again.
- R8: `busy_o` is high exactly during integrate and run-down.
- R9: `res_under_o` is set when the reading is below `UNDER_LIM`. All result fields change together at the end of run-down.
- R10: `res_valid_o` rises with each new reading and falls after a cycle with `res_ready_i` high and no new reading. A new reading replaces an untaken one and keeps valid high. The fields do not change between readings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | 1 = convert continuously, 0 = park in zeroing after the current measurement |
| cmp_i | input | 1 | Synchronous comparator output, 1 = integrator above zero |
| phase_o | output | 4 | One-hot phase enables (zeroing, integrate, run-down, discharge) |
| busy_o | output | 1 | High during integrate and run-down |
| res_valid_o | output | 1 | Reading available |
| res_ready_i | input | 1 | Consumer takes the reading |
| res_count_o | output | RW | Run-down clock count (magnitude) |
| res_neg_o | output | 1 | Sign of the reading, 1 = negative input |
| res_ovr_o | output | 1 | Over-range flag |
| res_under_o | output | 1 | Under-range flag |

## Verification
Two functions can land in the same clock: latching a fresh reading at the end of run-down, and a consumer handshake on the reading still pending. The bench leaves one reading untaken through a parked hold. In the next measurement it raises `res_ready_i` on the same clock that it flips the comparator. It then expects `res_valid_o` still high with the new count and sign, which shows the new reading took priority over the acknowledge. A second collision sits between the comparator trip and the run-down timeout on the last allowed clock. The bench trips on clock `DE_MAX-1` and expects that count without the over-range flag.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2,
    PH_ZI  = 2'd3
  } phase_e;

  localparam int NUM_PHASES = 4;
endpackage

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
  import dslope_pkg::*;
#(
  parameter int INT_CYCLES = 10000,
  parameter int DE_MAX     = 20001,
  parameter int CW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          cmp_i,
  input  logic [CW-1:0] az_len_i,
  input  logic [CW-1:0] zi_len_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          pol_o,
  output logic          de_done_o,
  output logic          de_ovr_o
);
  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          pol_q;
  logic          last;
  logic          de_trip;
  logic          de_tmo;

  // run-down ends on a comparator change or when the slot is used up
  assign de_trip = (ph_q == PH_DE) && (cmp_i != pol_q);
  assign de_tmo  = (ph_q == PH_DE) && !de_trip && (cnt_q == CW'(DE_MAX - 1));

  always_comb begin
    unique case (ph_q)
      PH_AZ:   last = (cnt_q >= az_len_i - CW'(1));
      PH_INT:  last = (cnt_q == CW'(INT_CYCLES - 1));
      PH_DE:   last = de_trip || de_tmo;
      default: last = (cnt_q >= zi_len_i - CW'(1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_AZ;
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (last && (ph_q != PH_AZ || run_i)) begin
      ph_q  <= phase_e'(ph_q + 2'd1);
      cnt_q <= '0;
      if (ph_q == PH_INT) pol_q <= cmp_i;
    end else if (!last) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign phase_o   = ph_q;
  assign cnt_o     = cnt_q;
  assign pol_o     = pol_q;
  assign de_done_o = de_trip || de_tmo;
  assign de_ovr_o  = de_tmo;
endmodule

// File: rtl/dslope_az_budget.sv
module dslope_az_budget #(
  parameter int INT_CYCLES = 10000,
  parameter int DE_MAX     = 20001,
  parameter int ZI_NORM    = 200,
  parameter int ZI_OVR     = 6200,
  parameter int PERIOD     = 40002,
  parameter int CW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_done_i,
  input  logic          de_ovr_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] az_len_o,
  output logic [CW-1:0] zi_len_o
);
  localparam int AZ_BASE = PERIOD - INT_CYCLES - DE_MAX - ZI_NORM;
  localparam int AZ_OVR  = PERIOD - INT_CYCLES - DE_MAX - ZI_OVR;

  logic [CW-1:0] az_q, zi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      az_q <= CW'(AZ_BASE);
      zi_q <= CW'(ZI_NORM);
    end else if (de_done_i) begin
      if (de_ovr_i) begin
        az_q <= CW'(AZ_OVR);
        zi_q <= CW'(ZI_OVR);
      end else begin
        // unused run-down clocks move into zeroing
        az_q <= CW'(AZ_BASE + DE_MAX - 1) - cnt_i;
        zi_q <= CW'(ZI_NORM);
      end
    end
  end

  assign az_len_o = az_q;
  assign zi_len_o = zi_q;
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int DE_MAX    = 20001,
  parameter int UNDER_LIM = 1800,
  parameter int CW        = 16,
  parameter int RW        = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_done_i,
  input  logic          de_ovr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pol_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [RW-1:0] count_o,
  output logic          neg_o,
  output logic          ovr_o,
  output logic          under_o
);
  logic [RW-1:0] cnt_new;
  assign cnt_new = de_ovr_i ? RW'(DE_MAX) : RW'(cnt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      count_o <= '0;
      neg_o   <= 1'b0;
      ovr_o   <= 1'b0;
      under_o <= 1'b0;
    end else if (de_done_i) begin
      valid_o <= 1'b1;
      count_o <= cnt_new;
      neg_o   <= !pol_i;
      ovr_o   <= de_ovr_i;
      under_o <= (cnt_new < RW'(UNDER_LIM));
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int INT_CYCLES = 10000,
  parameter int DE_MAX     = 20001,
  parameter int ZI_NORM    = 200,
  parameter int ZI_OVR     = 6200,
  parameter int PERIOD     = 40002,
  parameter int UNDER_LIM  = 1800,
  localparam int CW        = $clog2(PERIOD + 1),
  localparam int RW        = $clog2(DE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          cmp_i,
  output logic [3:0]    phase_o,
  output logic          busy_o,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic [RW-1:0] res_count_o,
  output logic          res_neg_o,
  output logic          res_ovr_o,
  output logic          res_under_o
);
  phase_e        ph;
  logic [CW-1:0] cnt, az_len, zi_len;
  logic          pol, de_done, de_ovr;

  dslope_phase_ctrl #(.INT_CYCLES(INT_CYCLES), .DE_MAX(DE_MAX), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmp_i(cmp_i),
    .az_len_i(az_len), .zi_len_i(zi_len), .phase_o(ph), .cnt_o(cnt),
    .pol_o(pol), .de_done_o(de_done), .de_ovr_o(de_ovr));

  dslope_az_budget #(.INT_CYCLES(INT_CYCLES), .DE_MAX(DE_MAX), .ZI_NORM(ZI_NORM),
                     .ZI_OVR(ZI_OVR), .PERIOD(PERIOD), .CW(CW)) u_budget (
    .clk(clk), .rst_n(rst_n), .de_done_i(de_done), .de_ovr_i(de_ovr),
    .cnt_i(cnt), .az_len_o(az_len), .zi_len_o(zi_len));

  dslope_result #(.DE_MAX(DE_MAX), .UNDER_LIM(UNDER_LIM), .CW(CW), .RW(RW)) u_res (
    .clk(clk), .rst_n(rst_n), .de_done_i(de_done), .de_ovr_i(de_ovr),
    .cnt_i(cnt), .pol_i(pol), .ready_i(res_ready_i), .valid_o(res_valid_o),
    .count_o(res_count_o), .neg_o(res_neg_o), .ovr_o(res_ovr_o),
    .under_o(res_under_o));

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    assign phase_o[g] = (ph == phase_e'(g));
  end

  assign busy_o = (ph == PH_INT) || (ph == PH_DE);
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int INT_CYCLES = 10000,
  parameter int DE_MAX     = 20001,
  parameter int RW         = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic [3:0]    phase_o,
  input logic          busy_o,
  input logic          res_valid_o,
  input logic          res_ready_i,
  input logic [RW-1:0] res_count_o,
  input logic          res_ovr_o
);
  int unsigned int_run, de_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_run <= 0;
      de_run  <= 0;
    end else begin
      int_run <= phase_o[1] ? int_run + 1 : 0;
      de_run  <= phase_o[2] ? de_run + 1 : 0;
    end
  end

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1);
  assert_int_after_az_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_o[1]) |-> $past(phase_o[0]));
  assert_int_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_o[1]) |-> int_run == INT_CYCLES);
  assert_de_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[2] |-> de_run < DE_MAX);
  assert_ovr_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovr_o |-> res_count_o == RW'(DE_MAX));
  assert_hold_az_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && phase_o[0]) |=> phase_o[0]);
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> phase_o[1]);
  assert_result_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_o[3]) |-> res_valid_o);
  assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i && !phase_o[2]) |=> (res_valid_o && $stable(res_count_o)));
endmodule

bind dslope_seq dslope_seq_chk #(.INT_CYCLES(INT_CYCLES), .DE_MAX(DE_MAX), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .phase_o(phase_o), .busy_o(busy_o),
  .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_count_o(res_count_o),
  .res_ovr_o(res_ovr_o));

// File: tb/dslope_seq_bench.sv
`timescale 1ns/1ps
module dslope_seq_bench;
  localparam int INT_C = 20;
  localparam int DEM   = 41;
  localparam int ZIN   = 4;
  localparam int ZIO   = 12;
  localparam int PER   = 82;
  localparam int UND   = 8;
  localparam int RW    = $clog2(DEM + 1);
  localparam int NV    = 7;

  // trip clock (99 = never), polarity, then expected count/neg/ovr/under/ZI/AZ
  localparam int VK[NV]   = '{5, 30, 40, 99, 0, 8, 7};
  localparam int VP[NV]   = '{1, 0, 1, 1, 0, 1, 0};
  localparam int EC[NV]   = '{5, 30, 40, 41, 0, 8, 7};
  localparam int EN[NV]   = '{0, 1, 0, 0, 1, 0, 1};
  localparam int EO[NV]   = '{0, 0, 0, 1, 0, 0, 0};
  localparam int EU[NV]   = '{1, 0, 0, 0, 1, 0, 1};
  localparam int EZ[NV]   = '{4, 4, 4, 12, 4, 4, 4};
  localparam int EA[NV]   = '{52, 27, 17, 9, 57, 49, 50};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1;
  logic cmp = 1'b0;
  logic rdy = 1'b0;
  logic [3:0] phase;
  logic busy, vld, neg, ovr, under;
  logic [RW-1:0] cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dslope_seq #(.INT_CYCLES(INT_C), .DE_MAX(DEM), .ZI_NORM(ZIN), .ZI_OVR(ZIO),
               .PERIOD(PER), .UNDER_LIM(UND)) u_dslope_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run), .cmp_i(cmp), .phase_o(phase),
    .busy_o(busy), .res_valid_o(vld), .res_ready_i(rdy), .res_count_o(cnt),
    .res_neg_o(neg), .res_ovr_o(ovr), .res_under_o(under));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // integrate with polarity p, then run-down tripping at clock k; returns integrate length
  task automatic convert(input int k, input int p, input bit ack_at_trip, output int ilen);
    cmp = p[0];
    ilen = 0;
    while (phase[1]) begin
      @(negedge clk);
      ilen++;
    end
    for (int d = 0; phase[2]; d++) begin
      if (d == k) begin
        cmp = !p[0];
        if (ack_at_trip) rdy = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int ilen, z, a;
    repeat (4) @(negedge clk);
    chk("R1 reset phase", phase, 4'b0001);
    chk("R8 reset busy", busy, 0);
    chk("R10 reset valid", vld, 0);
    rst_n = 1'b1;
    while (!phase[1]) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      chk("R1 integrate one-hot", phase, 4'b0010);
      chk("R8 busy in integrate", busy, 1);
      convert(VK[i], VP[i], 1'b0, ilen);
      chk("R2 integrate length", ilen, INT_C);
      chk("R1 discharge follows run-down", phase, 4'b1000);
      chk("R10 valid after run-down", vld, 1);
      chk("R3 count", cnt, EC[i]);
      chk("R2 sign", neg, EN[i]);
      chk("R4 over-range", ovr, EO[i]);
      chk("R9 under-range", under, EU[i]);
      z = 0;
      while (phase[3]) begin
        if (z == 0) rdy = 1'b1;
        if (z == 1) begin
          rdy = 1'b0;
          chk("R10 valid cleared by ready", vld, 0);
        end
        @(negedge clk);
        z++;
      end
      chk("R5 discharge length", z, EZ[i]);
      chk("R8 busy idle", busy, 0);
      a = 0;
      while (phase[0]) begin
        @(negedge clk);
        a++;
      end
      chk("R6 zeroing length", a, EA[i]);
    end

    // hold: conversion in progress completes, then parks in zeroing (R7)
    run = 1'b0;
    convert(10, 1, 1'b0, ilen);
    chk("R7 reading after hold request", cnt, 10);
    repeat (200) @(negedge clk);
    chk("R7 parked in zeroing", phase, 4'b0001);
    chk("R7 reading kept", cnt, 10);
    chk("R10 untaken reading still valid", vld, 1);
    run = 1'b1;
    @(negedge clk);
    chk("R7 integrate one clock after run", phase, 4'b0010);

    // new reading and ready in the same clock: new reading wins (R10)
    convert(12, 0, 1'b1, ilen);
    rdy = 1'b0;
    chk("R10 collision keeps valid", vld, 1);
    chk("R10 collision new count", cnt, 12);
    chk("R2 collision sign", neg, 1);
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    chk("R10 ack after collision", vld, 0);
    summary();
  end
endmodule